// File: doc/BRIEF.md
# Fixed-Point RK4 Chen Attractor Generator

This block integrates the three-variable Chen chaotic system in hardware with the classical fourth-order Runge-Kutta method. All arithmetic is signed Q16.16 on 32 bits, so the coefficients, the step size and the start point are built in. Each integration step evaluates the slope four times, one clock cycle per evaluation, and then updates x, y and z together.

After every step the block streams the new state out to an external DAC as three words on one 32-bit bus. A write strobe marks each word, and a two-bit tag says which variable the word carries. The `run` input starts the stream and stops it at a step boundary. An asynchronous active-low reset puts the trajectory back at its start point.

Top module: `chen_rk4_gen`

## Requirements
- R1: An active-low `rst_n` acts asynchronously. While it is low, `dac_wr` is 0. It returns x, y and z to 1.0 (65536 in Q16.16) and the controller to idle. The first triple written after reset release is therefore the result of integration step one.
- R2: A multiply forms the full 64-bit signed product and shifts it right arithmetically by 16. If the result lies outside the signed 32-bit range it saturates to 2147483647 or -2147483648; otherwise it keeps the low 32 bits. Additions and subtractions wrap at 32 bits.
- R3: The slopes at a point (x,y,z) are dx = mul(35·65536, y−x); dy = mul(−7·65536, x) − mul(x, z) + mul(28·65536, y); dz = mul(x, y) − mul(3·65536, z).
- R4: Stage n gives k_n = mul(655, slope at the stage-n evaluation point). The evaluation points are s, then s + (k1>>>1), then s + (k2>>>1), then s + k3. The shifts are arithmetic and applied per variable.
- R5: At the end of a step every variable becomes s + mul(k1 + (k2<<<1) + (k3<<<1) + k4, 10923). The sum is formed in 32-bit wrapping arithmetic.
- R6: After each step the block writes on three consecutive cycles with `dac_wr` high. The tag `dac_sel` is 0 with x, then 1 with y, then 2 with z, and `dac_data` carries the freshly updated value. The tag value 3 never appears with a write.
- R7: `run` is sampled only while idle and in the cycle of the z write. When it is low the block goes idle, writes nothing and holds its state. Raising `run` again continues the trajectory from the held state.
- R8: While `run` stays high, each step takes 7 cycles: four slope cycles and three write cycles. Consecutive x writes are therefore exactly 7 cycles apart, and the cycle right after a z write carries no strobe.
- R9: During the first 1000 steps from reset, x and y stay strictly between −50.0 and 50.0, and z stays at or above 0.0 and below 60.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start/continue request, sampled at step boundaries |
| dac_data | output | 32 | Q16.16 state word for the DAC, zero when no write |
| dac_wr | output | 1 | Write strobe, one cycle per word |
| dac_sel | output | 2 | Variable tag: 0 = x, 1 = y, 2 = z |

## Verification
The assertions assume that `run` is synchronous to `clk` and that `rst_n` is released away from a rising edge. The stepping-rate property also relies on `run` being high in the z-write cycle. The bench changes `run` and `rst_n` only on falling edges, so both assumptions hold. The bench drops `run` partway through the trajectory and resets the block both between runs and in the middle of a slope stage. Through all of this it compares every written word bit for bit against an independent Q16.16 model of the integration.

// File: rtl/chen_rk4_gen.sv
module chen_rk4_gen #(
  parameter int W       = 32,
  parameter int FRAC    = 16,
  parameter int COEF_A  = 35,
  parameter int COEF_B  = 3,
  parameter int COEF_C  = 28,
  parameter int STEP_Q  = 655,
  parameter int SIXTH_Q = 10923,
  parameter int INIT_I  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] dac_data,
  output logic         dac_wr,
  output logic [1:0]   dac_sel
);

  localparam logic signed [W-1:0] QA    = W'(COEF_A * (2 ** FRAC));
  localparam logic signed [W-1:0] QB    = W'(COEF_B * (2 ** FRAC));
  localparam logic signed [W-1:0] QC    = W'(COEF_C * (2 ** FRAC));
  localparam logic signed [W-1:0] QCMA  = W'((COEF_C - COEF_A) * (2 ** FRAC));
  localparam logic signed [W-1:0] QH    = W'(STEP_Q);
  localparam logic signed [W-1:0] QS    = W'(SIXTH_Q);
  localparam logic signed [W-1:0] QINIT = W'(INIT_I * (2 ** FRAC));
  localparam logic signed [W-1:0] SMAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN  = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] qmul(input logic signed [W-1:0] p,
                                               input logic signed [W-1:0] q);
    logic signed [2*W-1:0] full, sh;
    full = (2*W)'(p) * (2*W)'(q);
    sh   = full >>> FRAC;
    if (sh > (2*W)'(SMAX))      return SMAX;
    else if (sh < (2*W)'(SMIN)) return SMIN;
    else                        return sh[W-1:0];
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_K3, S_K4, S_WX, S_WY, S_WZ} phase_t;
  phase_t ph;

  logic signed [W-1:0] sx, sy, sz;
  logic signed [W-1:0] px, py, pz;
  logic signed [W-1:0] ax, ay, az;
  logic signed [W-1:0] ox, oy, oz;
  logic signed [W-1:0] ex, ey, ez;
  logic signed [W-1:0] dx, dy, dz;
  logic signed [W-1:0] kx, ky, kz;

  always_comb begin
    case (ph)
      S_K2, S_K3: begin ox = px >>> 1; oy = py >>> 1; oz = pz >>> 1; end
      S_K4:       begin ox = px;       oy = py;       oz = pz;       end
      default:    begin ox = '0;       oy = '0;       oz = '0;       end
    endcase
  end

  assign ex = sx + ox;
  assign ey = sy + oy;
  assign ez = sz + oz;

  assign dx = qmul(QA, ey - ex);
  assign dy = qmul(QCMA, ex) - qmul(ex, ez) + qmul(QC, ey);
  assign dz = qmul(ex, ey) - qmul(QB, ez);

  assign kx = qmul(QH, dx);
  assign ky = qmul(QH, dy);
  assign kz = qmul(QH, dz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE;
      sx <= QINIT; sy <= QINIT; sz <= QINIT;
      px <= '0;    py <= '0;    pz <= '0;
      ax <= '0;    ay <= '0;    az <= '0;
    end else begin
      case (ph)
        S_IDLE: if (run) ph <= S_K1;
        S_K1: begin
          px <= kx; py <= ky; pz <= kz;
          ax <= kx; ay <= ky; az <= kz;
          ph <= S_K2;
        end
        S_K2, S_K3: begin
          px <= kx; py <= ky; pz <= kz;
          ax <= ax + (kx <<< 1);
          ay <= ay + (ky <<< 1);
          az <= az + (kz <<< 1);
          ph <= (ph == S_K2) ? S_K3 : S_K4;
        end
        S_K4: begin
          sx <= sx + qmul(ax + kx, QS);
          sy <= sy + qmul(ay + ky, QS);
          sz <= sz + qmul(az + kz, QS);
          ph <= S_WX;
        end
        S_WX: ph <= S_WY;
        S_WY: ph <= S_WZ;
        S_WZ: ph <= run ? S_K1 : S_IDLE;
        default: ph <= S_IDLE;
      endcase
    end
  end

  assign dac_wr  = (ph == S_WX) || (ph == S_WY) || (ph == S_WZ);
  assign dac_sel = (ph == S_WY) ? 2'd1 : (ph == S_WZ) ? 2'd2 : 2'd0;
  assign dac_data = (ph == S_WX) ? sx :
                    (ph == S_WY) ? sy :
                    (ph == S_WZ) ? sz : '0;

endmodule

module chen_rk4_gen_chk #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic [W-1:0] dac_data,
  input logic         dac_wr,
  input logic [1:0]   dac_sel
);
  localparam logic signed [W-1:0] XHI = W'(50 * (2 ** FRAC));
  localparam logic signed [W-1:0] XLO = W'(-50 * (2 ** FRAC));

  always @(negedge clk) if (!rst_n) AST_RESET_QUIET: assert (!dac_wr); // R1

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> dac_sel != 2'd3); // R6
  AST_X_THEN_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr && dac_sel == 2'd0) |=> (dac_wr && dac_sel == 2'd1)); // R6
  AST_Y_THEN_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr && dac_sel == 2'd1) |=> (dac_wr && dac_sel == 2'd2)); // R6
  AST_STEP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr && dac_sel == 2'd2 && run) |=> !dac_wr ##4 (dac_wr && dac_sel == 2'd0)); // R8
  AST_Z_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr && dac_sel == 2'd2) |=> !dac_wr); // R8
  AST_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr && dac_sel == 2'd0) |-> ($signed(dac_data) < XHI && $signed(dac_data) > XLO)); // R9
endmodule

bind chen_rk4_gen chen_rk4_gen_chk u_chk (.*);

// File: tb/sim_chen_rk4_gen.sv
`timescale 1ns/1ps
module sim_chen_rk4_gen;
  logic        clk = 0, rst_n = 0, run = 0;
  logic [31:0] dac_data;
  logic        dac_wr;
  logic [1:0]  dac_sel;

  chen_rk4_gen u0 (.clk(clk), .rst_n(rst_n), .run(run),
                   .dac_data(dac_data), .dac_wr(dac_wr), .dac_sel(dac_sel));

  always #2.5 clk = ~clk;

  int          n_chk = 0, n_fail = 0;
  logic [33:0] expq[$];
  int          rs[3];
  bit          mon_on = 1, gap_ok = 1, have_x = 0;
  longint      cyc = 0, last_x = 0;
  int          wr_count = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qm(int a, int b);
    longint p, q;
    p = longint'(a) * longint'(b);
    q = p >>> 16;
    if (q > 64'sd2147483647) return 32'sh7fffffff;
    if (q < -64'sd2147483648) return 32'sh80000000;
    return int'(q);
  endfunction

  task automatic ref_init();
    for (int i = 0; i < 3; i++) rs[i] = 65536;
  endtask

  task automatic ref_steps(int n);
    for (int s = 0; s < n; s++) begin
      int kp[3], acc[3], e[3], d[3], k[3];
      for (int st = 0; st < 4; st++) begin
        for (int i = 0; i < 3; i++)
          e[i] = rs[i] + ((st == 0) ? 0 : (st == 3) ? kp[i] : (kp[i] >>> 1));
        d[0] = qm(35 * 65536, e[1] - e[0]);
        d[1] = qm(-7 * 65536, e[0]) - qm(e[0], e[2]) + qm(28 * 65536, e[1]);
        d[2] = qm(e[0], e[1]) - qm(3 * 65536, e[2]);
        for (int i = 0; i < 3; i++) begin
          k[i] = qm(655, d[i]);
          if (st == 0)      acc[i] = k[i];
          else if (st == 3) acc[i] = acc[i] + k[i];
          else              acc[i] = acc[i] + (k[i] <<< 1);
          kp[i] = k[i];
        end
      end
      for (int i = 0; i < 3; i++) begin
        rs[i] = rs[i] + qm(acc[i], 10923);
        expq.push_back({2'(i), rs[i]});
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (dac_wr) wr_count++;
    if (mon_on && dac_wr) begin
      if (expq.size() == 0) begin
        chk(0, "R7 unexpected write", longint'(dac_sel), -1);
      end else begin
        logic [33:0] it;
        it = expq.pop_front();
        chk(dac_sel == it[33:32], "R6 tag order", longint'(dac_sel), longint'(it[33:32]));
        chk(dac_data == it[31:0], "R2 R3 R4 R5 state word",
            longint'($signed(dac_data)), longint'($signed(it[31:0])));
        if (dac_sel == 2'd2)
          chk($signed(dac_data) >= 0 && $signed(dac_data) < 60 * 65536, "R9 z bound",
              longint'($signed(dac_data)), 0);
        else
          chk($signed(dac_data) > -50 * 65536 && $signed(dac_data) < 50 * 65536, "R9 x/y bound",
              longint'($signed(dac_data)), 0);
        if (dac_sel == 2'd0) begin
          if (have_x && gap_ok) chk(cyc - last_x == 7, "R8 step period", cyc - last_x, 7);
          have_x = 1;
          last_x = cyc;
        end
      end
    end
  end

  // driver
  initial begin
    int base;
    ref_init();
    ref_steps(1000);
    repeat (3) @(negedge clk);
    chk(dac_wr == 0, "R1 no strobe in reset", longint'(dac_wr), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(dac_wr == 0 && wr_count == 0, "R7 idle while run low", wr_count, 0);
    run = 1;
    while (expq.size() > 1500) @(negedge clk);
    gap_ok = 0;
    run = 0;
    repeat (12) @(negedge clk);
    base = wr_count;
    chk(expq.size() % 3 == 0, "R7 stop on whole triple", expq.size() % 3, 0);
    repeat (30) @(negedge clk);
    chk(wr_count == base, "R7 no writes while stopped", wr_count, base);
    run = 1;
    while (expq.size() > 0) @(negedge clk);
    rst_n = 0;
    #1;
    chk(dac_wr == 0, "R1 async reset quiets strobe", longint'(dac_wr), 0);
    ref_init();
    ref_steps(4);
    repeat (2) @(negedge clk);
    rst_n = 1;
    while (expq.size() > 6) @(negedge clk);
    repeat (2) @(negedge clk);
    rst_n = 0;
    #1;
    chk(dac_wr == 0, "R1 reset mid-stage", longint'(dac_wr), 0);
    expq.delete();
    ref_init();
    ref_steps(3);
    repeat (2) @(negedge clk);
    rst_n = 1;
    while (expq.size() > 0) @(negedge clk);
    mon_on = 0;
    run = 0;
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R1 restart sequence consumed", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule